// File: doc/BRIEF.md
# Multiplexed LCD Scan Controller

This block generates the drive-level codes for a multiplexed segment LCD. Software writes a mode byte and a segment-enable byte through a small register port, and fills an internal display memory with one nibble per segment. Once the display is switched on with a valid scan length, a timing chain runs without further software action. The chain is a base-clock counter, then a power-of-two divider, then a phase counter. It steps through the active common lines. For each phase it drives every common and segment with a 2-bit level code.

The polarity of the drive flips at the end of every frame, so each pixel sees an average voltage of zero. The codes are digital: code 0 is the ground level (V0) and code 3 is the full-scale level (V3). Codes 1 and 2 are the intermediate levels. The analog ladder that turns codes into voltages lies outside this block.

Top module: `lcd_scan_ctrl`

## Requirements
- R1: The register at address 0 holds the mode byte: bit 0 enable, bits 2:1 scan length, bit 3 bias (0 = one-third, 1 = one-half), bits 5:4 divider, bit 6 clock source. Bit 7 always reads 0, and the byte changes only on a write.
- R2: While enable is 0, every common and segment output carries code 0. The prescaler, divider, phase and polarity are held at zero, so a new enable starts at phase 0 with positive polarity.
- R3: Scan length code 00 is reserved. With enable set and this code selected, all outputs stay at code 0 and no scanning takes place.
- R4: Scan length codes 01, 10 and 11 scan commons 0..1, 0..2 and 0..3 in ascending order. Common c is selected in phase c.
- R5: With clock source 0, one base tick occurs after every SUB_DIV pulses of `sub_tick`. With clock source 1, one base tick occurs every MAIN_DIV cycles of `clk`, and `sub_tick` is ignored.
- R6: Divider codes 00, 01, 10 and 11 advance the phase once every 1, 2, 4 or 8 base ticks.
- R7: After the last active common, the phase wraps to 0 and the frame polarity toggles. The first frame after enable has positive polarity.
- R8: In one-third bias, the selected common gets code 3 (positive frame) or 0 (negative frame), and unselected active commons get code 1 (positive) or 2 (negative). In one-half bias, the selected common is the same and unselected commons get code 1. Commons outside the scan length get code 0.
- R9: Display memory word s holds segment s, with bit n belonging to common n. A lit segment gets code 0 in a positive frame and code 3 in a negative frame. An unlit segment gets code 2/1 (one-third bias) or code 3/0 (one-half bias) in positive/negative frames.
- R10: The register at address 1 reads back in full. Its bit g enables segments 4g..4g+3, and a disabled segment carries code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sub_tick | input | 1 | One-cycle strobe marking a sub-clock edge |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 mode, 1 segment enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| ram_wr | input | 1 | Display memory write strobe |
| ram_addr | input | 5 | Display memory segment index |
| ram_wdata | input | 4 | Display memory nibble |
| com_lvl | output | 8 | Common level codes, common c at bits 2c+1:2c |
| seg_lvl | output | 64 | Segment level codes, segment s at bits 2s+1:2s |

## Verification
The assertions check these properties on every cycle:
- Outputs stay at ground whenever scanning is inactive.
- The phase never leaves the active range, and it moves only on a divided tick and only by one step or a wrap.
- Polarity flips exactly at a wrap.
- The mode byte changes only on a write.

Only the bench scenarios can show the following:
- The exact phase period for each source and divider.
- The complete level pattern for each scan length and bias.
- The mapping from memory bits to segments.
- The masking by segment groups.
- That the counters restart from zero after a reserved code or a disable.

// File: rtl/lcd_pkg.sv
// Package: shared level codes and the mode-register layout for the LCD scan controller.
// Assumes at most four commons, so the phase index is always two bits.
package lcd_pkg;
    typedef logic [1:0] lvl_t;
    localparam lvl_t LV0 = 2'd0;
    localparam lvl_t LV1 = 2'd1;
    localparam lvl_t LV2 = 2'd2;
    localparam lvl_t LV3 = 2'd3;

    typedef struct packed {
        logic       src;    // bit 6: 1 = main clock base, 0 = sub-clock base
        logic [1:0] div;    // bits 5:4: divide by 1/2/4/8
        logic       bias;   // bit 3: 1 = one-half, 0 = one-third
        logic [1:0] duty;   // bits 2:1: 00 reserved, else last common index
        logic       en;     // bit 0: display on
    } mode_t;
endpackage

// File: rtl/lcd_regs.sv
// Module: mode and segment-enable registers with read-back.
// Assumes NUM_GRP <= 8 so the enable byte fits one register.
module lcd_regs
    import lcd_pkg::*;
#(
    parameter int NUM_GRP = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic               addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    output mode_t              mode,
    output logic [NUM_GRP-1:0] seg_en
);
    // Register storage: written on a strobe, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= '0;
            seg_en <= '0;
        end else if (wr) begin
            if (!addr) mode   <= mode_t'(wdata[6:0]);
            else       seg_en <= wdata[NUM_GRP-1:0];
        end
    end

    // Read mux: unused bits return zero.
    always_comb begin
        rdata = '0;
        if (!addr) rdata[6:0] = mode;
        else begin
            for (int i = 0; i < NUM_GRP; i++) rdata[i] = seg_en[i];
        end
    end

    a_r1_mode_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && !addr) |=> $stable(mode));
    a_r1_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !addr |-> rdata[7] == 1'b0);
endmodule

// File: rtl/lcd_timing.sv
// Module: base-clock prescaler, power-of-two divider and phase/polarity counter.
// Assumes sub_tick is a single-cycle strobe synchronous to clk.
module lcd_timing
    import lcd_pkg::*;
#(
    parameter int SUB_DIV  = 32,
    parameter int MAIN_DIV = 8192
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sub_tick,
    input  mode_t      mode,
    output logic       active,
    output logic [1:0] phase,
    output logic       pol
);
    localparam int MAXDIV = (MAIN_DIV > SUB_DIV) ? MAIN_DIV : SUB_DIV;
    localparam int CW     = $clog2(MAXDIV);

    logic [CW-1:0] base_cnt;
    logic [2:0]    div_cnt;
    logic [2:0]    div_last;
    logic          base_tick;
    logic          phase_tick;
    logic [1:0]    last;

    assign active = mode.en && (mode.duty != 2'b00);
    assign last   = mode.duty;

    // Divider terminal count for the selected ratio.
    always_comb begin
        case (mode.div)
            2'd0:    div_last = 3'd0;
            2'd1:    div_last = 3'd1;
            2'd2:    div_last = 3'd3;
            default: div_last = 3'd7;
        endcase
    end

    assign base_tick = active && (mode.src ? (base_cnt == CW'(MAIN_DIV - 1))
                                           : (sub_tick && base_cnt == CW'(SUB_DIV - 1)));
    assign phase_tick = base_tick && (div_cnt >= div_last);

    // Prescaler: counts main cycles or sub-clock strobes up to one base tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !active)          base_cnt <= '0;
        else if (base_tick)             base_cnt <= '0;
        else if (mode.src || sub_tick)  base_cnt <= base_cnt + 1'b1;
    end

    // Divider: counts base ticks up to one phase step.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) div_cnt <= '0;
        else if (phase_tick)   div_cnt <= '0;
        else if (base_tick)    div_cnt <= div_cnt + 1'b1;
    end

    // Phase and frame polarity: step per divided tick, flip polarity on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            phase <= '0;
            pol   <= 1'b0;
        end else if (phase_tick) begin
            if (phase >= last) begin
                phase <= '0;
                pol   <= ~pol;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    a_r4_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> phase <= last);
    a_r4_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        active && phase_tick && phase < last |=> !active || phase == $past(phase) + 2'd1);
    a_r6_phase_holds: assert property (@(posedge clk) disable iff (!rst_n)
        active && !phase_tick |=> !active || ($stable(phase) && $stable(pol)));
    a_r7_pol_flip_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        active && phase_tick && phase >= last |=> !active || (phase == 2'd0 && pol != $past(pol)));
    a_r2_idle_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !active -> (phase == 2'd0 && !pol));
endmodule

// File: rtl/lcd_drive.sv
// Module: display memory and level encoder for commons and segments.
// Assumes the phase input is already limited to the active scan range.
module lcd_drive
    import lcd_pkg::*;
#(
    parameter int NUM_SEG = 32,
    parameter int SEG_GRP = 4,
    parameter int NUM_COM = 4,
    localparam int NUM_GRP = NUM_SEG / SEG_GRP,
    localparam int AW      = $clog2(NUM_SEG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ram_wr,
    input  logic [AW-1:0]        ram_addr,
    input  logic [NUM_COM-1:0]   ram_wdata,
    input  logic                 active,
    input  logic [1:0]           phase,
    input  logic                 pol,
    input  mode_t                mode,
    input  logic [NUM_GRP-1:0]   seg_en,
    output logic [2*NUM_COM-1:0] com_lvl,
    output logic [2*NUM_SEG-1:0] seg_lvl
);
    logic [NUM_COM-1:0] mem [NUM_SEG];

    // Display memory write port, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SEG; s++) mem[s] <= '0;
        end else if (ram_wr) begin
            mem[ram_addr] <= ram_wdata;
        end
    end

    // One encoder per common line.
    for (genvar c = 0; c < NUM_COM; c++) begin : g_com
        always_comb begin
            if (!active || c > int'(mode.duty))  com_lvl[2*c +: 2] = LV0;
            else if (c == int'(phase))           com_lvl[2*c +: 2] = pol ? LV0 : LV3;
            else if (mode.bias)                  com_lvl[2*c +: 2] = LV1;
            else                                 com_lvl[2*c +: 2] = pol ? LV2 : LV1;
        end
    end

    // One encoder per segment line.
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        logic lit;
        assign lit = mem[s][phase];
        always_comb begin
            if (!active || !seg_en[s / SEG_GRP]) seg_lvl[2*s +: 2] = LV0;
            else if (lit)                        seg_lvl[2*s +: 2] = pol ? LV3 : LV0;
            else if (mode.bias)                  seg_lvl[2*s +: 2] = pol ? LV0 : LV3;
            else                                 seg_lvl[2*s +: 2] = pol ? LV1 : LV2;
        end
    end

    a_r2_off_ground: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (com_lvl == '0 && seg_lvl == '0));
    a_r8_com0_driven: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> com_lvl[1:0] != LV0 || pol);
endmodule

// File: rtl/lcd_scan_ctrl.sv
// Module: top of the multiplexed LCD scan controller.
// Assumes four commons at most; outputs are level codes for an external ladder.
module lcd_scan_ctrl
    import lcd_pkg::*;
#(
    parameter int NUM_SEG  = 32,
    parameter int SEG_GRP  = 4,
    parameter int SUB_DIV  = 32,
    parameter int MAIN_DIV = 8192,
    localparam int NUM_COM = 4,
    localparam int NUM_GRP = NUM_SEG / SEG_GRP,
    localparam int AW      = $clog2(NUM_SEG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sub_tick,
    input  logic                 reg_wr,
    input  logic                 reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 ram_wr,
    input  logic [AW-1:0]        ram_addr,
    input  logic [NUM_COM-1:0]   ram_wdata,
    output logic [2*NUM_COM-1:0] com_lvl,
    output logic [2*NUM_SEG-1:0] seg_lvl
);
    mode_t              mode;
    logic [NUM_GRP-1:0] seg_en;
    logic               active;
    logic [1:0]         phase;
    logic               pol;

    lcd_regs #(.NUM_GRP(NUM_GRP)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .mode(mode), .seg_en(seg_en)
    );

    lcd_timing #(.SUB_DIV(SUB_DIV), .MAIN_DIV(MAIN_DIV)) u_timing (
        .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .mode(mode),
        .active(active), .phase(phase), .pol(pol)
    );

    lcd_drive #(.NUM_SEG(NUM_SEG), .SEG_GRP(SEG_GRP), .NUM_COM(NUM_COM)) u_drive (
        .clk(clk), .rst_n(rst_n), .ram_wr(ram_wr), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .active(active), .phase(phase), .pol(pol),
        .mode(mode), .seg_en(seg_en), .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );
endmodule

// File: tb/lcd_scan_ctrl_bench.sv
module lcd_scan_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sub_tick = 1'b1;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        ram_wr = 1'b0;
    logic [4:0]  ram_addr = '0;
    logic [3:0]  ram_wdata = '0;
    logic [7:0]  com_lvl;
    logic [63:0] seg_lvl;

    int checks = 0;
    int fails  = 0;
    int sub_mode = 0;   // 0 strobe always high, 1 every other cycle, 2 held low
    logic [3:0] mram [32];
    logic [7:0] en_mask = 8'hFF;

    always #4 clk = ~clk;

    lcd_scan_ctrl u_lcd_scan_ctrl (
        .clk(clk), .rst_n(rst_n), .sub_tick(sub_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ram_wr(ram_wr), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .com_lvl(com_lvl), .seg_lvl(seg_lvl)
    );

    // Sub-clock strobe pattern.
    always @(negedge clk) begin
        if (sub_mode == 0)      sub_tick <= 1'b1;
        else if (sub_mode == 1) sub_tick <= ~sub_tick;
        else                    sub_tick <= 1'b0;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic wr_ram(input int a, input logic [3:0] d);
        ram_wr = 1'b1; ram_addr = 5'(a); ram_wdata = d;
        @(negedge clk);
        ram_wr = 1'b0;
        mram[a] = d;
    endtask

    function automatic logic [7:0] mode_byte(int src, int dv, int bias, int duty, int en);
        return {1'b0, 1'(src), 2'(dv), 1'(bias), 2'(duty), 1'(en)};
    endfunction

    function automatic logic [7:0] exp_com(int ph, int pol, int duty, int bias);
        logic [7:0] r = '0;
        for (int c = 0; c < 4; c++) begin
            logic [1:0] v;
            if (c > duty)       v = 2'd0;
            else if (c == ph)   v = pol ? 2'd0 : 2'd3;
            else if (bias == 1) v = 2'd1;
            else                v = pol ? 2'd2 : 2'd1;
            r[2*c +: 2] = v;
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_seg(int ph, int pol, int bias);
        logic [63:0] r = '0;
        for (int s = 0; s < 32; s++) begin
            logic [1:0] v;
            if (!en_mask[s/4])       v = 2'd0;
            else if (mram[s][ph])    v = pol ? 2'd3 : 2'd0;
            else if (bias == 1)      v = pol ? 2'd0 : 2'd3;
            else                     v = pol ? 2'd1 : 2'd2;
            r[2*s +: 2] = v;
        end
        return r;
    endfunction

    // Count cycles until the common levels change (bounded).
    task automatic wait_change(output int n);
        logic [7:0] prev = com_lvl;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (com_lvl == prev && n < 20000);
    endtask

    // Scan frames for one configuration, checking levels and phase period.
    task automatic run_cfg(int src, int dv, int bias, int duty, int frames, int period);
        int n;
        wr_reg(1'b0, mode_byte(src, dv, bias, duty, 1));
        for (int f = 0; f < frames; f++) begin
            for (int p = 0; p <= duty; p++) begin
                check("R4/R7/R8 commons", 64'(com_lvl), 64'(exp_com(p, f % 2, duty, bias)));
                check("R9/R10 segments", seg_lvl, exp_seg(p, f % 2, bias));
                wait_change(n);
                check("R5/R6 phase period", 64'(n), 64'(period));
            end
        end
        wr_reg(1'b0, 8'h00);
    endtask

    initial begin
        int n;
        for (int s = 0; s < 32; s++) mram[s] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check("R2 reset commons", 64'(com_lvl), 64'h0);
        check("R2 reset segments", seg_lvl, 64'h0);
        check("R1 reset mode", 64'(reg_rdata), 64'h0);
        // R1 readback with bit 7 masked
        wr_reg(1'b0, 8'hFF);
        check("R1 mode readback", 64'(reg_rdata), 64'h7F);
        wr_reg(1'b0, 8'h00);
        // R10 full readback
        wr_reg(1'b1, 8'hA5);
        reg_addr = 1'b1; #1;
        check("R10 enable readback", 64'(reg_rdata), 64'hA5);
        reg_addr = 1'b0;
        wr_reg(1'b1, 8'hFF);
        en_mask = 8'hFF;
        for (int s = 0; s < 32; s++) wr_ram(s, 4'((s * 7 + 3) ^ (s >> 2)));
        // Sweep scan length, bias and divider with sub-clock source
        for (int duty = 1; duty <= 3; duty++)
            for (int bias = 0; bias < 2; bias++)
                for (int dv = 0; dv < 4; dv++)
                    run_cfg(0, dv, bias, duty, 2, 32 << dv);
        // R3 reserved scan length with enable: no scan, outputs at ground
        wr_reg(1'b0, mode_byte(0, 0, 0, 0, 1));
        n = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (com_lvl != 0 || seg_lvl != 0) n++;
        end
        check("R3 reserved stays off", 64'(n), 64'h0);
        // R3/R2 leaving reserved code starts from zeroed counters
        wr_reg(1'b0, mode_byte(0, 0, 0, 1, 1));
        check("R3 start phase0", 64'(com_lvl), 64'(exp_com(0, 0, 1, 0)));
        wait_change(n);
        check("R3 first period after reserved", 64'(n), 64'd32);
        // R2 disable mid-scan, then re-enable restarts frame
        wr_reg(1'b0, mode_byte(0, 0, 0, 3, 0));
        check("R2 disabled commons", 64'(com_lvl), 64'h0);
        check("R2 disabled segments", seg_lvl, 64'h0);
        repeat (50) @(negedge clk);
        run_cfg(0, 0, 0, 3, 1, 32);
        // R5 sub-clock strobe every other cycle doubles the period
        sub_mode = 1;
        @(negedge clk);
        run_cfg(0, 0, 1, 1, 1, 64);
        // R5 main clock source ignores the sub-clock strobe
        sub_mode = 2;
        wr_reg(1'b0, mode_byte(1, 0, 0, 2, 1));
        wait_change(n);
        check("R5 main source period", 64'(n), 64'd8192);
        wr_reg(1'b0, 8'h00);
        sub_mode = 0;
        // R10 group masking
        wr_reg(1'b1, 8'h0F);
        en_mask = 8'h0F;
        run_cfg(0, 0, 0, 3, 1, 32);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(negedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule